// File: doc/BRIEF.md
# PC Sampling Profile Register

This block sits on the debug side of a processor and offers an external profiler a non-intrusive view of where the core is executing. Every retirement strobe from the core records the retired instruction address along with its context: security state, privilege level, transactional flag, two context identifiers and a virtual-machine identifier. An external agent polls the block over a simple read-only request/response port.

Reading the low word of the sample register returns the low half of the most recent address. As a side effect, that read copies the high word (context bits and upper address) and the three identifier registers into holding registers. Later reads of those locations therefore describe the same sample as the low word, even if the core keeps retiring instructions. Debug state and a profiling prohibit both force a sentinel of all ones. A software lock suppresses the side effect. Access is refused with an error unless the core is powered and both the double lock and the OS lock are clear. An optional 64-bit read returns the low word and the freshly captured high word in one response.

Top module: `pc_sample_profiler`

## Requirements
- R1: The high word packs bit 63 = non-secure flag, bits 62:61 = privilege level (0 to 3), bit 60 = transactional flag, bits 59:56 = zero, bits 55:32 = address bits 55:32 of the sample.
- R2: A permitted low-word read (offset 0x200) with a retirement since the last consuming read returns the address bits 31:0 in rsp_data[31:0], with upper bits zero. It loads the held high word (0x204), context ID 1 (0x208), context ID 2 (0x20C) and VM ID (0x210) from that same sample. Those offsets return the held values, zero-extended.
- R3: While dbg_state or prof_prohibit is high, a low-word read returns 0xFFFFFFFF and loads FILL_WORD into the held high word and FILL_WORD's low bits into the three held ID registers.
- R4: A retired flag is set by a retirement strobe and cleared by a consuming low-word read, by either reset, and by any cycle with dbg_state or prof_prohibit high. A low-word read with the flag clear returns 0xFFFFFFFF and leaves all held registers unchanged.
- R5: While sw_lock is high, a low-word read returns its normal data but captures nothing and leaves the retired flag unchanged.
- R6: A request is refused unless core_powered is high and dbl_lock and os_lock are low. A refused request gives rsp_err = 1 and rsp_data = 0, and it changes no state.
- R7: Any write request gets rsp_err = 1 and changes no state.
- R8: The window 0x220 to 0x23F mirrors 0x200 to 0x21F exactly, including the capture side effect.
- R9: With ATOMIC_EN = 1, a read with req_wide set at the low-word offset returns {new held high word, low word} in one response, with the same side effects as a low-word read. A wide read at any other offset, or any wide read with ATOMIC_EN = 0, is an error.
- R10: Warm reset (warm_rst_n low) clears only the retired flag and keeps the sample and held registers. Cold reset (rst_n low) clears everything to zero.
- R11: Every request gets exactly one response in the following cycle (rsp_valid high for that one cycle). A read of an unmapped or misaligned address is an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, synchronous, active low |
| warm_rst_n | input | 1 | Warm reset, synchronous, active low; clears retired flag only |
| ret_valid | input | 1 | Retirement strobe |
| ret_pc | input | 56 | Retired instruction address |
| ret_ns | input | 1 | Non-secure flag of retirement |
| ret_el | input | 2 | Privilege level of retirement |
| ret_tx | input | 1 | Transactional flag of retirement |
| ret_ctx1 | input | CTX_W | Context identifier 1 |
| ret_ctx2 | input | CTX_W | Context identifier 2 |
| ret_vmid | input | VMID_W | Virtual-machine identifier |
| dbg_state | input | 1 | Core is in debug state |
| prof_prohibit | input | 1 | PC-sample profiling prohibited |
| core_powered | input | 1 | Core power domain is up |
| dbl_lock | input | 1 | Double lock is set |
| os_lock | input | 1 | OS lock is set |
| sw_lock | input | 1 | Software lock is set |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | Request is a write |
| req_wide | input | 1 | Request is a 64-bit read |
| req_addr | input | ADDR_W | Byte address of request |
| rsp_valid | output | 1 | Response valid (one cycle after request) |
| rsp_err | output | 1 | Response is an error |
| rsp_data | output | 64 | Read data |

## Verification
The bench builds two copies with CTX_W = 16 and VMID_W = 8: `dut` with ATOMIC_EN = 1 and a second copy with ATOMIC_EN = 0 on the same inputs. This lets both variants of the wide read be compared under one stimulus. The narrow identifiers keep the fill pattern truncation visible. They also allow a full sweep of the 16 combinations of security, level and transactional flag through both address windows. The gate and halt inputs are swept over all their combinations, and every word offset of the 64-byte window is probed for the mapped/unmapped split.

// File: rtl/pcs_pkg.sv
// Package: shared types and helpers for the PC sampling profile register.
// Assumes a 56-bit sampled address and 32-bit bus words.
package pcs_pkg;

    localparam int PC_W    = 56;
    localparam int WORD_W  = 32;
    localparam int HI_PC_W = PC_W - WORD_W;

    localparam logic [WORD_W-1:0] SENTINEL = '1;

    // Which held-register update a low-word read performs.
    typedef enum logic [1:0] {
        CAP_NONE,
        CAP_SAMPLE,
        CAP_FILL
    } cap_e;

    // Which register a request selects.
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LO,
        SEL_HI,
        SEL_CID1,
        SEL_CID2,
        SEL_VMID
    } sel_e;

    // Assemble the high word from context bits and upper address bits.
    function automatic logic [WORD_W-1:0] pack_hi(
        input logic               ns,
        input logic [1:0]         el,
        input logic               tx,
        input logic [HI_PC_W-1:0] pc_hi
    );
        return {ns, el, tx, 4'b0000, pc_hi};
    endfunction

endpackage

// File: rtl/pcs_sample_unit.sv
// Module: pcs_sample_unit
// Records the latest retirement (address plus context) and keeps the
// "retired since last consuming read" flag. Assumes one retirement per
// cycle at most. The sample registers clear only on cold reset.
module pcs_sample_unit
    import pcs_pkg::*;
#(
    parameter int CTX_W  = 32,
    parameter int VMID_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_rst_n,
    input  logic              ret_valid,
    input  logic [PC_W-1:0]   ret_pc,
    input  logic              ret_ns,
    input  logic [1:0]        ret_el,
    input  logic              ret_tx,
    input  logic [CTX_W-1:0]  ret_ctx1,
    input  logic [CTX_W-1:0]  ret_ctx2,
    input  logic [VMID_W-1:0] ret_vmid,
    input  logic              halted,
    input  logic              consume,
    output logic [PC_W-1:0]   smp_pc,
    output logic              smp_ns,
    output logic [1:0]        smp_el,
    output logic              smp_tx,
    output logic [CTX_W-1:0]  smp_ctx1,
    output logic [CTX_W-1:0]  smp_ctx2,
    output logic [VMID_W-1:0] smp_vmid,
    output logic              retired
);

    // Latch the latest retirement; only cold reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_pc   <= '0;
            smp_ns   <= 1'b0;
            smp_el   <= 2'b00;
            smp_tx   <= 1'b0;
            smp_ctx1 <= '0;
            smp_ctx2 <= '0;
            smp_vmid <= '0;
        end else if (ret_valid) begin
            smp_pc   <= ret_pc;
            smp_ns   <= ret_ns;
            smp_el   <= ret_el;
            smp_tx   <= ret_tx;
            smp_ctx1 <= ret_ctx1;
            smp_ctx2 <= ret_ctx2;
            smp_vmid <= ret_vmid;
        end
    end

    // Retired flag: halt clears, retirement sets, consuming read clears.
    always_ff @(posedge clk) begin
        if (!rst_n || !warm_rst_n) begin
            retired <= 1'b0;
        end else if (halted) begin
            retired <= 1'b0;
        end else if (ret_valid) begin
            retired <= 1'b1;
        end else if (consume) begin
            retired <= 1'b0;
        end
    end

endmodule

// File: rtl/pcs_access_ctrl.sv
// Module: pcs_access_ctrl
// Decodes a request into a register select and decides whether it is
// refused. Purely combinational. Assumes word-aligned 32-bit registers in
// a 64-byte window whose upper 32 bytes mirror the lower 32.
module pcs_access_ctrl
    import pcs_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE = ADDR_W'('h200),
    parameter bit              ATOMIC_EN = 1'b1
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              core_powered,
    input  logic              dbl_lock,
    input  logic              os_lock,
    output sel_e              acc_sel,
    output logic              acc_ok,
    output logic              acc_err
);

    localparam logic [ADDR_W-1:0] WIN_MASK = ~ADDR_W'('h3F);

    logic in_window;
    logic gate_open;
    logic wide_bad;
    sel_e sel;

    // Map the window offset to a register; the alias bit 5 is ignored.
    always_comb begin
        in_window = (req_addr & WIN_MASK) == WIN_BASE;
        sel       = SEL_NONE;
        if (in_window) begin
            case (req_addr[4:0])
                5'h00:   sel = SEL_LO;
                5'h04:   sel = SEL_HI;
                5'h08:   sel = SEL_CID1;
                5'h0C:   sel = SEL_CID2;
                5'h10:   sel = SEL_VMID;
                default: sel = SEL_NONE;
            endcase
        end
    end

    // Wide reads are legal only at the low word and only when enabled.
    generate
        if (ATOMIC_EN) begin : g_wide
            assign wide_bad = req_wide && (sel != SEL_LO);
        end else begin : g_narrow
            assign wide_bad = req_wide;
        end
    endgenerate

    // Combine gating, direction and decode into accept / refuse.
    always_comb begin
        gate_open = core_powered && !dbl_lock && !os_lock;
        acc_err   = req_valid &&
                    (!gate_open || req_write || (sel == SEL_NONE) || wide_bad);
        acc_ok    = req_valid && !acc_err;
        acc_sel   = acc_ok ? sel : SEL_NONE;
    end

endmodule

// File: rtl/pcs_hold_regs.sv
// Module: pcs_hold_regs
// Holding registers loaded by a low-word read: the high word and the three
// identifier registers. Also presents the value the high word takes after
// this cycle's update, for a wide read. Clears on cold reset only.
module pcs_hold_regs
    import pcs_pkg::*;
#(
    parameter int                CTX_W     = 32,
    parameter int                VMID_W    = 16,
    parameter logic [WORD_W-1:0] FILL_WORD = 32'h0BAD_F11D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cap_e              cap_mode,
    input  logic [WORD_W-1:0] smp_hi,
    input  logic [CTX_W-1:0]  smp_ctx1,
    input  logic [CTX_W-1:0]  smp_ctx2,
    input  logic [VMID_W-1:0] smp_vmid,
    output logic [WORD_W-1:0] held_hi,
    output logic [CTX_W-1:0]  held_ctx1,
    output logic [CTX_W-1:0]  held_ctx2,
    output logic [VMID_W-1:0] held_vmid,
    output logic [WORD_W-1:0] nxt_hi
);

    logic [CTX_W-1:0]  nxt_ctx1;
    logic [CTX_W-1:0]  nxt_ctx2;
    logic [VMID_W-1:0] nxt_vmid;

    // Choose the next held values from the capture mode.
    always_comb begin
        case (cap_mode)
            CAP_SAMPLE: begin
                nxt_hi   = smp_hi;
                nxt_ctx1 = smp_ctx1;
                nxt_ctx2 = smp_ctx2;
                nxt_vmid = smp_vmid;
            end
            CAP_FILL: begin
                nxt_hi   = FILL_WORD;
                nxt_ctx1 = FILL_WORD[CTX_W-1:0];
                nxt_ctx2 = FILL_WORD[CTX_W-1:0];
                nxt_vmid = FILL_WORD[VMID_W-1:0];
            end
            default: begin
                nxt_hi   = held_hi;
                nxt_ctx1 = held_ctx1;
                nxt_ctx2 = held_ctx2;
                nxt_vmid = held_vmid;
            end
        endcase
    end

    // Register the held values; warm reset does not reach here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_hi   <= '0;
            held_ctx1 <= '0;
            held_ctx2 <= '0;
            held_vmid <= '0;
        end else begin
            held_hi   <= nxt_hi;
            held_ctx1 <= nxt_ctx1;
            held_ctx2 <= nxt_ctx2;
            held_vmid <= nxt_vmid;
        end
    end

endmodule

// File: rtl/pc_sample_profiler.sv
// Module: pc_sample_profiler (top)
// PC sampling profile register with a read-only request/response port.
// A low-word read returns the sampled address and freezes the companion
// registers. Assumes CTX_W and VMID_W are at most 32 and ADDR_W >= 10.
module pc_sample_profiler
    import pcs_pkg::*;
#(
    parameter int                CTX_W     = 32,
    parameter int                VMID_W    = 16,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE  = ADDR_W'('h200),
    parameter bit                ATOMIC_EN = 1'b1,
    parameter logic [31:0]       FILL_WORD = 32'h0BAD_F11D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_rst_n,
    input  logic              ret_valid,
    input  logic [55:0]       ret_pc,
    input  logic              ret_ns,
    input  logic [1:0]        ret_el,
    input  logic              ret_tx,
    input  logic [CTX_W-1:0]  ret_ctx1,
    input  logic [CTX_W-1:0]  ret_ctx2,
    input  logic [VMID_W-1:0] ret_vmid,
    input  logic              dbg_state,
    input  logic              prof_prohibit,
    input  logic              core_powered,
    input  logic              dbl_lock,
    input  logic              os_lock,
    input  logic              sw_lock,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_data
);

    logic [PC_W-1:0]   smp_pc;
    logic              smp_ns;
    logic [1:0]        smp_el;
    logic              smp_tx;
    logic [CTX_W-1:0]  smp_ctx1;
    logic [CTX_W-1:0]  smp_ctx2;
    logic [VMID_W-1:0] smp_vmid;
    logic              retired;
    logic              halted;
    logic              lo_read;
    logic              consume;
    cap_e              cap_mode;
    sel_e              acc_sel;
    logic              acc_ok;
    logic              acc_err;
    logic [WORD_W-1:0] smp_hi;
    logic [WORD_W-1:0] held_hi;
    logic [CTX_W-1:0]  held_ctx1;
    logic [CTX_W-1:0]  held_ctx2;
    logic [VMID_W-1:0] held_vmid;
    logic [WORD_W-1:0] nxt_hi;
    logic [WORD_W-1:0] lo_word;
    logic [63:0]       rd_data;
    logic [WORD_W-1:0] ext_ctx1;
    logic [WORD_W-1:0] ext_ctx2;
    logic [WORD_W-1:0] ext_vmid;

    pcs_sample_unit #(.CTX_W(CTX_W), .VMID_W(VMID_W)) u_sample (
        .clk        (clk),
        .rst_n      (rst_n),
        .warm_rst_n (warm_rst_n),
        .ret_valid  (ret_valid),
        .ret_pc     (ret_pc),
        .ret_ns     (ret_ns),
        .ret_el     (ret_el),
        .ret_tx     (ret_tx),
        .ret_ctx1   (ret_ctx1),
        .ret_ctx2   (ret_ctx2),
        .ret_vmid   (ret_vmid),
        .halted     (halted),
        .consume    (consume),
        .smp_pc     (smp_pc),
        .smp_ns     (smp_ns),
        .smp_el     (smp_el),
        .smp_tx     (smp_tx),
        .smp_ctx1   (smp_ctx1),
        .smp_ctx2   (smp_ctx2),
        .smp_vmid   (smp_vmid),
        .retired    (retired)
    );

    pcs_access_ctrl #(
        .ADDR_W    (ADDR_W),
        .WIN_BASE  (WIN_BASE),
        .ATOMIC_EN (ATOMIC_EN)
    ) u_access (
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_wide     (req_wide),
        .req_addr     (req_addr),
        .core_powered (core_powered),
        .dbl_lock     (dbl_lock),
        .os_lock      (os_lock),
        .acc_sel      (acc_sel),
        .acc_ok       (acc_ok),
        .acc_err      (acc_err)
    );

    pcs_hold_regs #(
        .CTX_W     (CTX_W),
        .VMID_W    (VMID_W),
        .FILL_WORD (FILL_WORD)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_mode  (cap_mode),
        .smp_hi    (smp_hi),
        .smp_ctx1  (smp_ctx1),
        .smp_ctx2  (smp_ctx2),
        .smp_vmid  (smp_vmid),
        .held_hi   (held_hi),
        .held_ctx1 (held_ctx1),
        .held_ctx2 (held_ctx2),
        .held_vmid (held_vmid),
        .nxt_hi    (nxt_hi)
    );

    // Decide the low-word value and the capture side effect.
    always_comb begin
        halted  = dbg_state || prof_prohibit;
        lo_read = acc_ok && (acc_sel == SEL_LO);
        consume = lo_read && !sw_lock;
        smp_hi  = pack_hi(smp_ns, smp_el, smp_tx, smp_pc[PC_W-1:WORD_W]);
        lo_word = (halted || !retired) ? SENTINEL : smp_pc[WORD_W-1:0];
        if (!consume)      cap_mode = CAP_NONE;
        else if (halted)   cap_mode = CAP_FILL;
        else if (!retired) cap_mode = CAP_NONE;
        else               cap_mode = CAP_SAMPLE;
    end

    // Zero-extend the identifier registers to a bus word.
    always_comb begin
        ext_ctx1 = '0;
        ext_ctx2 = '0;
        ext_vmid = '0;
        ext_ctx1[CTX_W-1:0]  = held_ctx1;
        ext_ctx2[CTX_W-1:0]  = held_ctx2;
        ext_vmid[VMID_W-1:0] = held_vmid;
    end

    // Select read data for the accepted register.
    always_comb begin
        case (acc_sel)
            SEL_LO:   rd_data = req_wide ? {nxt_hi, lo_word} : {32'h0, lo_word};
            SEL_HI:   rd_data = {32'h0, held_hi};
            SEL_CID1: rd_data = {32'h0, ext_ctx1};
            SEL_CID2: rd_data = {32'h0, ext_ctx2};
            SEL_VMID: rd_data = {32'h0, ext_vmid};
            default:  rd_data = '0;
        endcase
    end

    // Register the one-cycle response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= acc_err;
            rsp_data  <= rd_data;
        end
    end

endmodule

// File: rtl/pcs_checker.sv
// Module: pcs_checker
// Property checks for pc_sample_profiler, attached with bind below.
module pcs_checker #(
    parameter int CTX_W  = 32,
    parameter int VMID_W = 16,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              warm_rst_n,
    input logic              ret_valid,
    input logic              dbg_state,
    input logic              prof_prohibit,
    input logic              core_powered,
    input logic              dbl_lock,
    input logic              os_lock,
    input logic              sw_lock,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_wide,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [63:0]       rsp_data,
    input logic              retired,
    input logic [31:0]       held_hi,
    input logic [CTX_W-1:0]  held_ctx1,
    input logic [CTX_W-1:0]  held_ctx2,
    input logic [VMID_W-1:0] held_vmid
);

    logic gate_open;
    logic lo_addr;
    assign gate_open = core_powered && !dbl_lock && !os_lock;
    assign lo_addr   = (req_addr == ADDR_W'('h200)) || (req_addr == ADDR_W'('h220));

    a_r6_refused: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !gate_open |=> rsp_err && rsp_data == 64'h0);

    a_r7_write_err: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write |=> rsp_err);

    a_r11_resp_one: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r3_sentinel: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && !req_wide && gate_open && lo_addr &&
        (dbg_state || prof_prohibit)
        |=> !rsp_err && rsp_data == 64'h0000_0000_FFFF_FFFF);

    a_r5_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        sw_lock |=> $stable(held_hi) && $stable(held_ctx1) &&
                    $stable(held_ctx2) && $stable(held_vmid));

    a_r4_halt_clears: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_state || prof_prohibit |=> !retired);

    a_r4_retire_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid && warm_rst_n && !dbg_state && !prof_prohibit |=> retired);

    a_r10_warm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !warm_rst_n |=> !retired);

endmodule

bind pc_sample_profiler pcs_checker #(
    .CTX_W  (CTX_W),
    .VMID_W (VMID_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .warm_rst_n    (warm_rst_n),
    .ret_valid     (ret_valid),
    .dbg_state     (dbg_state),
    .prof_prohibit (prof_prohibit),
    .core_powered  (core_powered),
    .dbl_lock      (dbl_lock),
    .os_lock       (os_lock),
    .sw_lock       (sw_lock),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_wide      (req_wide),
    .req_addr      (req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_err       (rsp_err),
    .rsp_data      (rsp_data),
    .retired       (retired),
    .held_hi       (held_hi),
    .held_ctx1     (held_ctx1),
    .held_ctx2     (held_ctx2),
    .held_vmid     (held_vmid)
);

// File: tb/tb_pc_sample_profiler.sv
`timescale 1ns/1ps
module tb_pc_sample_profiler;

    localparam int          CW   = 16;
    localparam int          VW   = 8;
    localparam logic [31:0] FILL = 32'h0BAD_F11D;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0, warm_rst_n = 1'b1;
    logic          ret_valid = 1'b0;
    logic [55:0]   ret_pc = '0;
    logic          ret_ns = 1'b0, ret_tx = 1'b0;
    logic [1:0]    ret_el = '0;
    logic [CW-1:0] ret_ctx1 = '0, ret_ctx2 = '0;
    logic [VW-1:0] ret_vmid = '0;
    logic          dbg_state = 1'b0, prof_prohibit = 1'b0;
    logic          core_powered = 1'b1, dbl_lock = 1'b0, os_lock = 1'b0, sw_lock = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [11:0]   req_addr = '0;
    logic          rsp_valid, rsp_err, rsp_valid2, rsp_err2;
    logic [63:0]   rsp_data, rsp_data2;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // model of held registers
    logic [31:0]   m_hi;
    logic [CW-1:0] m_c1, m_c2;
    logic [VW-1:0] m_vm;
    logic [55:0]   s_pc;
    logic [31:0]   s_hi;
    logic [CW-1:0] s_c1, s_c2;
    logic [VW-1:0] s_vm;

    always #4 clk = ~clk;

    pc_sample_profiler #(.CTX_W(CW), .VMID_W(VW), .ATOMIC_EN(1'b1), .FILL_WORD(FILL)) dut (
        .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n), .ret_valid(ret_valid),
        .ret_pc(ret_pc), .ret_ns(ret_ns), .ret_el(ret_el), .ret_tx(ret_tx),
        .ret_ctx1(ret_ctx1), .ret_ctx2(ret_ctx2), .ret_vmid(ret_vmid),
        .dbg_state(dbg_state), .prof_prohibit(prof_prohibit), .core_powered(core_powered),
        .dbl_lock(dbl_lock), .os_lock(os_lock), .sw_lock(sw_lock), .req_valid(req_valid),
        .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data));

    pc_sample_profiler #(.CTX_W(CW), .VMID_W(VW), .ATOMIC_EN(1'b0), .FILL_WORD(FILL)) dut_narrow (
        .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n), .ret_valid(ret_valid),
        .ret_pc(ret_pc), .ret_ns(ret_ns), .ret_el(ret_el), .ret_tx(ret_tx),
        .ret_ctx1(ret_ctx1), .ret_ctx2(ret_ctx2), .ret_vmid(ret_vmid),
        .dbg_state(dbg_state), .prof_prohibit(prof_prohibit), .core_powered(core_powered),
        .dbl_lock(dbl_lock), .os_lock(os_lock), .sw_lock(sw_lock), .req_valid(req_valid),
        .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
        .rsp_valid(rsp_valid2), .rsp_err(rsp_err2), .rsp_data(rsp_data2));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
    endtask

    // Drive one retirement; expected high word per R1 layout.
    task automatic retire(input logic [55:0] pc, input logic ns, input logic [1:0] el,
                          input logic tx, input logic [CW-1:0] c1, input logic [CW-1:0] c2,
                          input logic [VW-1:0] vm);
        @(negedge clk);
        ret_valid = 1'b1; ret_pc = pc; ret_ns = ns; ret_el = el; ret_tx = tx;
        ret_ctx1 = c1; ret_ctx2 = c2; ret_vmid = vm;
        @(negedge clk);
        ret_valid = 1'b0;
        s_pc = pc; s_hi = {ns, el, tx, 4'b0000, pc[55:32]};
        s_c1 = c1; s_c2 = c2; s_vm = vm;
    endtask

    // One request; response sampled at the following negedge.
    task automatic access(input logic [11:0] a, input logic wr, input logic wide);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_wide = wide;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wide = 1'b0;
    endtask

    function automatic logic [63:0] z(input logic [31:0] w);
        return {32'h0, w};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_hi = '0; m_c1 = '0; m_c2 = '0; m_vm = '0;

        // R10 cold reset state and R4 empty flag
        access(12'h204, 0, 0);
        chk("R10 cold reset high word", rsp_data, 64'h0);
        chk("R10 reset resp ok", {63'h0, rsp_err}, 64'h0);
        access(12'h200, 0, 0);
        chk("R4 no retirement sentinel", rsp_data, z(32'hFFFF_FFFF));
        access(12'h208, 0, 0);
        chk("R10 cold reset ctx1", rsp_data, 64'h0);

        // R1 R2 R8 sweep over context bits, alternating alias window
        for (int i = 0; i < 16; i++) begin
            logic [11:0] b;
            b = (i % 2 == 1) ? 12'h220 : 12'h200;
            retire({24'h300000 + 24'(i), 32'h8000_0000 + 32'(i * 4)}, i[0], i[2:1], i[3],
                   CW'(16'h1100 + i), CW'(16'h2200 + i), VW'(8'h40 + i));
            access(b, 0, 0);
            chk("R2 R8 low word", rsp_data, z(s_pc[31:0]));
            m_hi = s_hi; m_c1 = s_c1; m_c2 = s_c2; m_vm = s_vm;
            access(b + 12'h4, 0, 0);
            chk("R1 high word layout", rsp_data, z(m_hi));
            access(b + 12'h8, 0, 0);
            chk("R2 ctx1", rsp_data, z(32'(m_c1)));
            if (i % 4 == 0) begin
                access(b + 12'hC, 0, 0);
                chk("R2 ctx2", rsp_data, z(32'(m_c2)));
                access(b + 12'h10, 0, 0);
                chk("R2 vmid", rsp_data, z(32'(m_vm)));
            end
        end

        // R4 consumed: second read sentinel, no capture
        retire(56'h12_3456_0000_0100, 1, 2'd1, 0, 16'hAAAA, 16'hBBBB, 8'hCC);
        access(12'h200, 0, 0);
        chk("R2 new sample low", rsp_data, z(s_pc[31:0]));
        m_hi = s_hi; m_c1 = s_c1; m_c2 = s_c2; m_vm = s_vm;
        retire(56'h77_0000_0000_0200, 0, 2'd3, 1, 16'h1234, 16'h5678, 8'h9A);
        access(12'h200, 0, 0);
        access(12'h200, 0, 0);
        chk("R4 second read sentinel", rsp_data, z(32'hFFFF_FFFF));
        m_hi = s_hi; m_c1 = s_c1; m_c2 = s_c2; m_vm = s_vm;
        access(12'h204, 0, 0);
        chk("R4 no capture after consume", rsp_data, z(m_hi));

        // R3 debug/prohibit combos force sentinel and fill
        for (int k = 1; k < 4; k++) begin
            retire(56'h01_0000_0000_0300 + 56'(k), 1, 2'd2, 0, 16'h3333, 16'h4444, 8'h55);
            @(negedge clk); dbg_state = k[0]; prof_prohibit = k[1];
            access(12'h200, 0, 0);
            chk("R3 halted sentinel", rsp_data, z(32'hFFFF_FFFF));
            access(12'h204, 0, 0);
            chk("R3 fill high", rsp_data, z(FILL));
            access(12'h20C, 0, 0);
            chk("R3 fill ctx2", rsp_data, z(32'(FILL[CW-1:0])));
            access(12'h210, 0, 0);
            chk("R3 fill vmid", rsp_data, z(32'(FILL[VW-1:0])));
            @(negedge clk); dbg_state = 0; prof_prohibit = 0;
            access(12'h200, 0, 0);
            chk("R4 halt cleared flag", rsp_data, z(32'hFFFF_FFFF));
        end
        m_hi = FILL; m_c1 = FILL[CW-1:0]; m_c2 = FILL[CW-1:0]; m_vm = FILL[VW-1:0];

        // R4 a one-cycle halt pulse clears the flag
        retire(56'h02_0000_0000_0400, 0, 2'd0, 0, 16'h0101, 16'h0202, 8'h03);
        @(negedge clk); dbg_state = 1; @(negedge clk); dbg_state = 0;
        access(12'h200, 0, 0);
        chk("R4 debug pulse clears flag", rsp_data, z(32'hFFFF_FFFF));
        access(12'h204, 0, 0);
        chk("R4 flag-clear read keeps held", rsp_data, z(m_hi));

        // R5 software lock suppresses capture and keeps flag
        retire(56'h05_1111_2222_3330, 1, 2'd1, 1, 16'h5151, 16'h5252, 8'h53);
        @(negedge clk); sw_lock = 1;
        access(12'h200, 0, 0);
        chk("R5 locked read data", rsp_data, z(s_pc[31:0]));
        access(12'h204, 0, 0);
        chk("R5 locked no capture high", rsp_data, z(m_hi));
        access(12'h208, 0, 0);
        chk("R5 locked no capture ctx1", rsp_data, z(32'(m_c1)));
        @(negedge clk); sw_lock = 0;
        access(12'h200, 0, 0);
        chk("R5 flag kept through lock", rsp_data, z(s_pc[31:0]));
        m_hi = s_hi; m_c1 = s_c1; m_c2 = s_c2; m_vm = s_vm;
        access(12'h204, 0, 0);
        chk("R5 capture after unlock", rsp_data, z(m_hi));

        // R6 gating sweep
        retire(56'h06_0000_0000_0600, 0, 2'd2, 1, 16'h6161, 16'h6262, 8'h63);
        for (int g = 0; g < 8; g++) begin
            bit open;
            open = g[0] && !g[1] && !g[2];
            if (!open) begin
                @(negedge clk); core_powered = g[0]; dbl_lock = g[1]; os_lock = g[2];
                access(12'h200, 0, 0);
                chk("R6 refused err", {63'h0, rsp_err}, 64'h1);
                chk("R6 refused data", rsp_data, 64'h0);
            end
        end
        @(negedge clk); core_powered = 1; dbl_lock = 0; os_lock = 0;

        // R7 write refused, no side effect
        access(12'h200, 1, 0);
        chk("R7 write err", {63'h0, rsp_err}, 64'h1);
        access(12'h200, 0, 0);
        chk("R6 R7 no state change", rsp_data, z(s_pc[31:0]));
        m_hi = s_hi; m_c1 = s_c1; m_c2 = s_c2; m_vm = s_vm;
        access(12'h224, 0, 0);
        chk("R8 alias high", rsp_data, z(m_hi));

        // R11 address map sweep and response timing
        for (int w = 0; w < 16; w++) begin
            logic [4:0] off;
            bit mapped;
            off = 5'((w % 8) * 4);
            mapped = (off <= 5'h10);
            access(12'h200 + 12'(w * 4), 0, 0);
            chk("R11 map err", {63'h0, rsp_err}, {63'h0, !mapped});
            chk("R11 resp valid", {63'h0, rsp_valid}, 64'h1);
        end
        access(12'h201, 0, 0);
        chk("R11 misaligned err", {63'h0, rsp_err}, 64'h1);
        access(12'h100, 0, 0);
        chk("R11 outside window err", {63'h0, rsp_err}, 64'h1);
        @(negedge clk);
        chk("R11 single-cycle valid", {63'h0, rsp_valid}, 64'h0);

        // R9 wide reads
        retire(56'h09_ABCD_1234_5670, 1, 2'd3, 1, 16'h9191, 16'h9292, 8'h93);
        access(12'h200, 0, 1);
        chk("R9 wide combined", rsp_data, {s_hi, s_pc[31:0]});
        chk("R9 narrow build wide err", {63'h0, rsp_err2}, 64'h1);
        m_hi = s_hi;
        access(12'h220, 0, 1);
        chk("R9 wide flag clear", rsp_data, {m_hi, 32'hFFFF_FFFF});
        access(12'h204, 0, 1);
        chk("R9 wide at high err", {63'h0, rsp_err}, 64'h1);
        retire(56'h0A_0000_0000_0A00, 0, 2'd0, 0, 16'hA1A1, 16'hA2A2, 8'hA3);
        @(negedge clk); prof_prohibit = 1;
        access(12'h200, 0, 1);
        chk("R9 R3 wide halted", rsp_data, {FILL, 32'hFFFF_FFFF});
        @(negedge clk); prof_prohibit = 0;
        m_hi = FILL;

        // R10 warm reset keeps held/sample, clears flag
        retire(56'h0B_0000_0000_0B00, 1, 2'd1, 0, 16'hB1B1, 16'hB2B2, 8'hB3);
        access(12'h200, 0, 0);
        m_hi = s_hi; m_c1 = s_c1;
        retire(56'h0C_0000_0000_0C00, 0, 2'd2, 1, 16'hC1C1, 16'hC2C2, 8'hC3);
        @(negedge clk); warm_rst_n = 0; @(negedge clk); warm_rst_n = 1;
        access(12'h204, 0, 0);
        chk("R10 warm keeps high", rsp_data, z(m_hi));
        access(12'h208, 0, 0);
        chk("R10 warm keeps ctx1", rsp_data, z(32'(m_c1)));
        access(12'h200, 0, 0);
        chk("R10 warm clears flag", rsp_data, z(32'hFFFF_FFFF));
        retire(56'h0D_0000_0000_0D00, 0, 2'd0, 1, 16'hD1D1, 16'hD2D2, 8'hD3);
        access(12'h200, 0, 0);
        chk("R10 sample survives warm path", rsp_data, z(32'h0000_0D00));

        // R10 cold reset clears held registers
        @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
        access(12'h204, 0, 0);
        chk("R10 cold clears high", rsp_data, 64'h0);

        summary();
        $finish;
    end

endmodule